// File: doc/BRIEF.md
# Mux-Scan Chain Tester

This block holds two small state machines, a 3-bit one (machine A) and a 2-bit one (machine B). Every state flip-flop sits behind a 2-to-1 multiplexer. In functional mode a flip-flop loads its next-state value. In scan mode it loads the output of its neighbour. The five flip-flops form one serial chain. Cell 0 is at the serial input end and cell 4 drives the serial output `dout`. All cells share one clock; only the data path is switched.

A built-in sequencer runs a complete structural test when `start` is pulsed. It loads each of seven patterns with five shifts. It then gives the machines one functional clock, so their next-state logic result is captured into the chain. While the next pattern shifts in, the previous response shifts out. A five-clock tail unloads the last response. Each unloaded response appears on `response` together with a one-cycle `respValid` strobe. The whole run takes 47 clocks, after which `done` goes high. When no run is active, `scanOverride` forces scan mode so the chain can be emptied serially. Otherwise the machines run freely.

Top module: `scan_chain_tester`

## Requirements
- R1: While `rst` is high (synchronous, active high), `dout`, `respValid`, `done` and `response` are all 0, and every chain cell is cleared.
- R2: When idle with `scanOverride` low, each clock applies the next-state logic. Cells 0..2 hold A bits 0..2 and cells 3..4 hold B bits 0..1. The new A is (A + B + 1) mod 8, the new B is B XOR {A[2],A[1]}, and `dout` is cell 4.
- R3: When idle with `scanOverride` high, each clock moves every cell one place toward `dout` and loads 0 into cell 0. `dout` therefore presents cell 4, then cell 3, down to cell 0, and then zeros.
- R4: After the clock that accepts `start`, a run lasts exactly 47 clocks, and `done` is high right after the 47th of them.
- R5: The patterns are applied in this order: all zeros, then the one-hot codes with cell 0, 1, 2, 3, 4 set, then all ones. Each pattern is loaded with five shifts, and the bit meant for cell 4 enters first.
- R6: After each load the chain receives exactly one functional clock, so the captured response is the R2 next state of the loaded pattern.
- R7: `respValid` pulses for one cycle, exactly seven times per run, in pattern order. With each pulse, `response` (bit i = cell i) carries the captured response, and `response` holds between pulses. The last pulse coincides with the rise of `done`.
- R8: During each unload, the five `dout` values before the `respValid` pulse, taken oldest first, equal `response` bits 4 down to 0.
- R9: While a run is active, `start` and `scanOverride` are ignored, and the run's timing and responses are unchanged.
- R10: `done` stays high until the next `start` is accepted, and it is low on the cycle after that. After a run the chain holds all zeros and the machines resume R2 operation from that state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all cells and the sequencer |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a test run while idle |
| scanOverride | input | 1 | Forces scan shifting while idle |
| dout | output | 1 | Serial chain output (cell 4) |
| respValid | output | 1 | One-cycle strobe: a complete response was unloaded |
| response | output | 5 | Last unloaded response, bit i from cell i |
| done | output | 1 | High once a run has finished |

## Verification
A wrong next-state term in either machine shows up in functional mode within a few clocks, as a divergent `dout` sequence from the reset state. In a run it corrupts the matching response at the next `respValid`, at most ten clocks after its pattern was loaded. A wrong shift direction, link or load order makes the one-hot responses disagree with the pattern order or with the serial `dout` history at the very first strobes. A sequencer slot-count error moves the `respValid` pulses and the `done` edge off clock 47, and checking that edge exposes it by the end of a single run.

// File: rtl/scan_test_pkg.sv
package scan_test_pkg;

  // Strobes from the sequencer to the chain datapath
  typedef struct packed {
    logic scanMode;     // 1: cells take neighbour, 0: cells take next state
    logic serialIn;     // bit entering cell 0 when shifting
    logic collect;      // dout carries a valid response bit this cycle
    logic collectLast;  // final response bit of an unload
  } scan_ctrl_t;

endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst,
  input  logic scanMode,
  input  logic funcD,
  input  logic scanD,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= scanMode ? scanD : funcD;
  end

endmodule

// File: rtl/scan_fsm_logic.sv
module scan_fsm_logic #(
  parameter int A_BITS = 3,
  parameter int B_BITS = 2
) (
  input  logic [A_BITS-1:0] stateA,
  input  logic [B_BITS-1:0] stateB,
  output logic [A_BITS-1:0] nextA,
  output logic [B_BITS-1:0] nextB
);

  // Machine A: counts by B+1; machine B: toggled by the top bits of A (R2)
  always_comb begin
    nextA = stateA + A_BITS'(stateB) + A_BITS'(1);
    nextB = stateB ^ stateA[A_BITS-1 -: B_BITS];
  end

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_test_pkg::*;
#(
  parameter int A_BITS = 3,
  parameter int B_BITS = 2,
  localparam int CHAIN = A_BITS + B_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  scan_ctrl_t       ctrl,
  output logic             dout,
  output logic             respValid,
  output logic [CHAIN-1:0] response
);

  logic [CHAIN-1:0]  chainQ;
  logic [CHAIN-1:0]  funcNext;
  logic [A_BITS-1:0] nextA;
  logic [B_BITS-1:0] nextB;
  logic [CHAIN-2:0]  rxShift;
  logic [CHAIN-1:0]  rxGrown;

  scan_fsm_logic #(.A_BITS(A_BITS), .B_BITS(B_BITS)) u_logic (
    .stateA(chainQ[A_BITS-1:0]),
    .stateB(chainQ[CHAIN-1:A_BITS]),
    .nextA (nextA),
    .nextB (nextB)
  );

  assign funcNext = {nextB, nextA};

  // One mux-D cell per state bit, linked from cell 0 toward dout
  for (genvar i = 0; i < CHAIN; i++) begin : g_cell
    logic scanSrc;
    if (i == 0) begin : g_head
      assign scanSrc = ctrl.serialIn;
    end else begin : g_link
      assign scanSrc = chainQ[i-1];
    end
    scan_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .scanMode(ctrl.scanMode),
      .funcD   (funcNext[i]),
      .scanD   (scanSrc),
      .q       (chainQ[i])
    );
  end

  assign dout    = chainQ[CHAIN-1];
  assign rxGrown = {rxShift, dout};

  // Response collector: first bit out is the highest cell (R8)
  always_ff @(posedge clk) begin
    if (rst) begin
      rxShift   <= '0;
      response  <= '0;
      respValid <= 1'b0;
    end else begin
      respValid <= ctrl.collectLast;
      if (ctrl.collect)     rxShift  <= rxGrown[CHAIN-2:0];
      if (ctrl.collectLast) response <= rxGrown;
    end
  end

  p_shift_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl.scanMode |=> (chainQ[CHAIN-1:1] == $past(chainQ[CHAIN-2:0])));

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    respValid |=> !respValid);

  p_resp_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !respValid |-> $stable(response));

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_test_pkg::*;
#(
  parameter int CHAIN_LEN = 5,
  localparam int NUM_VEC = CHAIN_LEN + 2,
  localparam int TOTAL   = NUM_VEC * (CHAIN_LEN + 1) + CHAIN_LEN,
  localparam int SLOT_W  = $clog2(CHAIN_LEN + 1),
  localparam int VEC_W   = $clog2(NUM_VEC + 1),
  localparam int CNT_W   = $clog2(TOTAL + 2)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       scanOverride,
  output scan_ctrl_t ctrl,
  output logic       done
);

  logic                 running;
  logic [SLOT_W-1:0]    slot;
  logic [VEC_W-1:0]     vecIdx;
  logic [CHAIN_LEN-1:0] loadReg;
  logic                 tail;
  logic                 loadSlot;
  logic                 finishing;
  logic [CNT_W-1:0]     runCount;

  // Pattern order (R5): zeros, one-hot cell 0..N-1, ones; zero past the end
  function automatic logic [CHAIN_LEN-1:0] vecPattern(input int idx);
    logic [CHAIN_LEN-1:0] p;
    if (idx == 0 || idx >= NUM_VEC) p = '0;
    else if (idx <= CHAIN_LEN)      p = CHAIN_LEN'(1) << (idx - 1);
    else                            p = '1;
    return p;
  endfunction

  always_comb begin
    tail      = (vecIdx == VEC_W'(NUM_VEC));
    loadSlot  = (slot < SLOT_W'(CHAIN_LEN));
    finishing = running && tail && (slot == SLOT_W'(CHAIN_LEN - 1));
    ctrl.scanMode    = scanOverride;
    ctrl.serialIn    = 1'b0;
    ctrl.collect     = 1'b0;
    ctrl.collectLast = 1'b0;
    if (running) begin
      ctrl.scanMode    = tail || loadSlot;   // capture slot is functional (R6)
      ctrl.serialIn    = loadReg[CHAIN_LEN-1];
      ctrl.collect     = ctrl.scanMode && (vecIdx != '0);
      ctrl.collectLast = ctrl.collect && (slot == SLOT_W'(CHAIN_LEN - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      slot    <= '0;
      vecIdx  <= '0;
      loadReg <= '0;
      done    <= 1'b0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        slot    <= '0;
        vecIdx  <= '0;
        loadReg <= vecPattern(0);
        done    <= 1'b0;
      end
    end else if (finishing) begin
      running <= 1'b0;
      slot    <= '0;
      done    <= 1'b1;
    end else if (slot == SLOT_W'(CHAIN_LEN)) begin
      slot    <= '0;
      vecIdx  <= vecIdx + VEC_W'(1);
      loadReg <= vecPattern(int'(vecIdx) + 1);
    end else begin
      slot    <= slot + SLOT_W'(1);
      loadReg <= loadReg << 1;
    end
  end

  // Independent run-length counter guarding the cycle budget
  always_ff @(posedge clk) begin
    if (rst)                    runCount <= '0;
    else if (!running && start) runCount <= '0;
    else if (running)           runCount <= runCount + CNT_W'(1);
  end

  p_run_length_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (runCount == CNT_W'(TOTAL)));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !running);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (running && start && !finishing) |=> (running && !done));

endmodule

// File: rtl/scan_chain_tester.sv
module scan_chain_tester
  import scan_test_pkg::*;
#(
  parameter int A_BITS = 3,
  parameter int B_BITS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     scanOverride,
  output logic                     dout,
  output logic                     respValid,
  output logic [A_BITS+B_BITS-1:0] response,
  output logic                     done
);

  localparam int CHAIN = A_BITS + B_BITS;

  scan_ctrl_t ctrl;

  scan_sequencer #(.CHAIN_LEN(CHAIN)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .scanOverride(scanOverride),
    .ctrl        (ctrl),
    .done        (done)
  );

  scan_datapath #(.A_BITS(A_BITS), .B_BITS(B_BITS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .dout     (dout),
    .respValid(respValid),
    .response (response)
  );

  p_done_valid_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> respValid);

endmodule

// File: tb/sim_scan_chain_tester.sv
module sim_scan_chain_tester;

  localparam int C   = 5;
  localparam int NV  = 7;
  localparam int TOT = 47;

  localparam logic [C-1:0] VEC_TABLE [NV] = '{
    5'b00000, 5'b00001, 5'b00010, 5'b00100, 5'b01000, 5'b10000, 5'b11111
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, start, scanOverride;
  logic dout, respValid, done;
  logic [C-1:0] response;
  logic [C-1:0] chainM;
  int testCount = 0;
  int failCount = 0;

  scan_chain_tester u0 (
    .clk(clk), .rst(rst), .start(start), .scanOverride(scanOverride),
    .dout(dout), .respValid(respValid), .response(response), .done(done)
  );

  function automatic logic [C-1:0] nsModel(input logic [C-1:0] c);
    logic [2:0] a, na;
    logic [1:0] b, nb;
    a  = c[2:0];
    b  = c[4:3];
    na = a + {1'b0, b} + 3'd1;
    nb = b ^ a[2:1];
    return {nb, na};
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Idle stepping with a reference chain model (R2 / R3)
  task automatic idleSteps(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      chainM = scanOverride ? {chainM[C-2:0], 1'b0} : nsModel(chainM);
      @(negedge clk);
      check(dout == chainM[C-1], tag, int'(dout), int'(chainM[C-1]));
    end
  endtask

  task automatic runTest(input bit interfere);
    logic [C-1:0] hist;
    int n, respIdx;
    bit gotDone;
    hist = '0; n = 0; respIdx = 0; gotDone = 0;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R10 done cleared on start", int'(done), 0);
    while (n < 60 && !gotDone) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (respValid) begin
        if (respIdx < NV) begin
          check(response == nsModel(VEC_TABLE[respIdx]), "R5 R6 captured response",
                int'(response), int'(nsModel(VEC_TABLE[respIdx])));
          check(hist == response, "R8 serial unload order", int'(hist), int'(response));
        end
        respIdx++;
      end
      hist = {hist[C-2:0], dout};
      if (done) begin
        gotDone = 1;
        check(n == TOT, "R4 run length", n, TOT);
        check(respIdx == NV, "R7 response count", respIdx, NV);
        check(respValid == 1'b1, "R7 last strobe with done", int'(respValid), 1);
      end
      if (interfere && n == 20) begin start = 1'b1; scanOverride = 1'b1; end
      if (interfere && n == 22) begin start = 1'b0; scanOverride = 1'b0; end
    end
    check(gotDone, interfere ? "R9 run completes despite inputs" : "R4 done seen",
          int'(gotDone), 1);
    // After the run: zeros in chain, functional again, done and response held
    chainM = '0;
    idleSteps(6, "R10 functional after run");
    check(done == 1'b1, "R10 done holds", int'(done), 1);
    check(respValid == 1'b0, "R7 strobe single", int'(respValid), 0);
    check(response == nsModel(VEC_TABLE[NV-1]), "R7 response held",
          int'(response), int'(nsModel(VEC_TABLE[NV-1])));
  endtask

  initial begin
    #(4 * 100000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; scanOverride = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dout == 1'b0,      "R1 reset dout",      int'(dout), 0);
    check(respValid == 1'b0, "R1 reset respValid", int'(respValid), 0);
    check(done == 1'b0,      "R1 reset done",      int'(done), 0);
    check(response == '0,    "R1 reset response",  int'(response), 0);
    rst = 1'b0;
    chainM = '0;
    idleSteps(12, "R2 functional stepping");
    // Override while idle: shift toward dout, zeros enter (R3)
    scanOverride = 1'b1;
    idleSteps(7, "R3 override shift");
    scanOverride = 1'b0;
    idleSteps(3, "R2 resume after override");
    // Let the chain pick up a non-zero state, then unload it serially
    idleSteps(6, "R2 functional stepping");
    scanOverride = 1'b1;
    idleSteps(6, "R3 override unload order");
    scanOverride = 1'b0;
    runTest(1'b0);
    runTest(1'b1);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule